// File: doc/BRIEF.md
# Tick-Driven Real-Time-Clock Interrupt Emulator

This block rebuilds the three classic real-time-clock interrupt sources from one programmable timer tick: the once-per-second update event, the time-of-day alarm and the periodic interrupt. It compares a free-running 32-bit counter against its own comparator value. When the counter reaches the comparator, that is a tick. The block then moves the comparator forward by the tick interval, one step per clock cycle, until the comparator is ahead of the counter again.

Each step beyond the first means a tick interval was missed. These missed steps are reported as a lost-tick count. When the periodic source is enabled, the missed steps are also credited to the periodic divider, so the long-run periodic rate stays correct.

At every completed tick the block samples the current seconds value for the update event and the full hours/minutes/seconds for the alarm. It then emits a one-cycle interrupt pulse together with a 16-bit flag word. The calendar that produces the time fields and any register bus sit outside the block.

Top module: `rtc_tick_emu`

## Requirements
- R1: Reset state. After reset, `cmp_o` is 0 and `catchup_done_o`, `irq_o`, `lost_ticks_o` and `flags_o` are all 0.
- R2: Tick detection. A tick starts when two conditions hold:
  - the block is idle and at least one of the three enables is 1;
  - the signed 32-bit value `counter_i - cmp_o` is greater than or equal to 0.
- R3: Catch-up. Once a tick starts, the comparator is increased by the interval once per clock cycle. Each increment happens at a rising edge, and the first one happens at the edge that detects the tick. The increments stop at the first one after which the signed 32-bit value `cmp_o - counter_i` is greater than 0.
- R4: Done strobe. `catchup_done_o` is high for exactly the cycle that follows the final increment. In that cycle, `lost_ticks_o` holds the number of increments minus one.
- R5: Interval. `rate_code_i` gives a requested periodic rate of 2^code Hz. Codes below 1 are clamped to 1 and codes above 13 are clamped to 13.
  - For codes 1 to 6, the interval is BASE_INTERVAL (the 64 Hz tick).
  - For codes 7 to 13, the interval is BASE_INTERVAL >> (code - 6), with a minimum of 1.
- R6: Periodic divider. The divider limit is 1 << (6 - code) for codes 1 to 6, and 1 for faster codes.
  - On each done strobe with `per_en_i` high, the divider adds 1 plus the lost-tick count.
  - When the sum reaches or exceeds the limit, the periodic flag is raised and the divider returns to 0.
  - While `per_en_i` is low, the divider is held at 0.
- R7: Update flag. While `upd_en_i` is high, the update flag is raised at a done strobe only if two conditions hold:
  - a seconds value has already been recorded since the enable went high;
  - `seconds_i` differs from that recorded value.
  
  The seconds value is recorded at every done strobe. While `upd_en_i` is low, the record is discarded, so the first change after enabling is not flagged.
- R8: Alarm flag. The alarm flag is raised at a done strobe when `alm_en_i` is high and hours, minutes and seconds all equal the alarm inputs.
- R9: Flag word. The flags appear in the cycle after the done strobe. If any flag is set, `irq_o` is high for that one cycle and `flags_o` contains:
  - bit 7: pending;
  - bit 6: periodic;
  - bit 5: alarm;
  - bit 4: update;
  - bits 15:8: the value 1;
  - bits 3:0: zero.
  
  If no flag is set, `irq_o` is low and `flags_o` is 0.
- R10: While all three enables are low and no catch-up is running, there are no ticks, no done strobes and no change of `cmp_o`, however far the counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| counter_i | input | 32 | Free-running main counter value |
| hours_i | input | 8 | Current hours |
| minutes_i | input | 8 | Current minutes |
| seconds_i | input | 8 | Current seconds |
| upd_en_i | input | 1 | Update interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| per_en_i | input | 1 | Periodic interrupt enable |
| alm_hours_i | input | 8 | Alarm hours |
| alm_minutes_i | input | 8 | Alarm minutes |
| alm_seconds_i | input | 8 | Alarm seconds |
| rate_code_i | input | 4 | Periodic rate as log2 of Hz |
| cmp_o | output | 32 | Tick comparator value |
| catchup_done_o | output | 1 | Comparator is ahead again (one cycle) |
| lost_ticks_o | output | 16 | Increments minus one of the last catch-up |
| irq_o | output | 1 | Interrupt pulse |
| flags_o | output | 16 | Interrupt count and flag byte |

## Verification
The assertions check four things on every cycle:
- that the flag word is consistent with the interrupt pulse;
- that each flag appears only when its enable was high;
- that the periodic divider clears after it fires;
- that the comparator stays frozen while every enable is low.

The bench scenarios are needed for the arithmetic. They show the exact comparator value after a catch-up of several lost intervals, the lost-tick count and the interval chosen for each rate code. They also show the divider's crediting of lost ticks across several ticks, and the suppression of the first seconds change after the update enable rises.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;

  localparam int unsigned RATE_MIN = 1;
  localparam int unsigned RATE_MAX = 13;
  localparam int unsigned RATE_TICK = 6;

  localparam int unsigned BIT_PEND = 7;
  localparam int unsigned BIT_PER  = 6;
  localparam int unsigned BIT_ALM  = 5;
  localparam int unsigned BIT_UPD  = 4;

  function automatic logic [3:0] clamp_rate(input logic [3:0] code);
    if (code < 4'(RATE_MIN)) return 4'(RATE_MIN);
    if (code > 4'(RATE_MAX)) return 4'(RATE_MAX);
    return code;
  endfunction

  function automatic logic [31:0] tick_interval(input logic [3:0] code,
                                                input logic [31:0] base);
    logic [3:0]  c;
    logic [31:0] iv;
    c = clamp_rate(code);
    if (c <= 4'(RATE_TICK)) begin
      iv = base;
    end else begin
      iv = base >> (c - 4'(RATE_TICK));
    end
    if (iv == 32'd0) iv = 32'd1;
    return iv;
  endfunction

  function automatic logic [5:0] div_limit(input logic [3:0] code);
    logic [3:0] c;
    c = clamp_rate(code);
    if (c <= 4'(RATE_TICK)) return 6'(1) << (4'(RATE_TICK) - c);
    return 6'd1;
  endfunction

  function automatic logic is_ahead(input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] d;
    d = $signed(a - b);
    return d > 0;
  endfunction

endpackage

// File: rtl/rtc_catchup.sv
module rtc_catchup
  import rtc_emu_pkg::*;
#(
  parameter int unsigned LOST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_en,
  input  logic [31:0]       counter,
  input  logic [31:0]       interval,
  output logic [31:0]       cmp,
  output logic              done,
  output logic [LOST_W-1:0] lost
);

  logic              busy;
  logic [LOST_W-1:0] steps;
  logic              fire;
  logic              step_now;
  logic [31:0]       cmp_nx;
  logic              ahead_nx;
  logic [LOST_W-1:0] steps_inc;

  assign fire      = !busy && any_en && !is_ahead(cmp, counter);
  assign step_now  = busy || fire;
  assign cmp_nx    = cmp + interval;
  assign ahead_nx  = is_ahead(cmp_nx, counter);
  assign steps_inc = (&steps) ? steps : steps + LOST_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp   <= '0;
      busy  <= 1'b0;
      steps <= '0;
      done  <= 1'b0;
      lost  <= '0;
    end else begin
      done <= 1'b0;
      if (step_now) begin
        cmp <= cmp_nx;
        if (ahead_nx) begin
          busy <= 1'b0;
          done <= 1'b1;
          lost <= busy ? steps : '0;
        end else begin
          busy  <= 1'b1;
          steps <= busy ? steps_inc : LOST_W'(1);
        end
      end
    end
  end

  a_r4_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && !busy) |=> $stable(cmp));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cmp == $past(cmp) + $past(interval)));

endmodule

// File: rtl/rtc_per_div.sv
module rtc_per_div
  import rtc_emu_pkg::*;
#(
  parameter int unsigned LOST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_en,
  input  logic              done,
  input  logic [LOST_W-1:0] lost,
  input  logic [3:0]        rate_code,
  output logic              per_hit
);

  localparam int unsigned SUM_W = LOST_W + 2;

  logic [5:0]       cnt;
  logic [SUM_W-1:0] sum;
  logic [5:0]       limit;

  assign limit   = div_limit(rate_code);
  assign sum     = SUM_W'(cnt) + SUM_W'(lost) + SUM_W'(1);
  assign per_hit = done && per_en && (sum >= SUM_W'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!per_en) begin
      cnt <= '0;
    end else if (done) begin
      cnt <= per_hit ? 6'd0 : sum[5:0];
    end
  end

  a_r6_clear_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    per_hit |=> (cnt == 6'd0));

  a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !per_en |=> (cnt == 6'd0));

endmodule

// File: rtl/rtc_flag_gen.sv
module rtc_flag_gen
  import rtc_emu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  logic        upd_en,
  input  logic        alm_en,
  input  logic        per_en,
  input  logic        per_hit,
  input  logic [7:0]  hours,
  input  logic [7:0]  minutes,
  input  logic [7:0]  seconds,
  input  logic [7:0]  alm_hours,
  input  logic [7:0]  alm_minutes,
  input  logic [7:0]  alm_seconds,
  output logic        irq,
  output logic [15:0] flags
);

  logic [7:0] last_sec;
  logic       last_valid;
  logic       upd_hit;
  logic       alm_hit;
  logic       any_hit;
  logic [7:0] flag_byte;

  assign upd_hit = done && upd_en && last_valid && (seconds != last_sec);
  assign alm_hit = done && alm_en && (hours == alm_hours) &&
                   (minutes == alm_minutes) && (seconds == alm_seconds);
  assign any_hit = upd_hit || alm_hit || per_hit;

  always_comb begin
    flag_byte           = '0;
    flag_byte[BIT_PEND] = any_hit;
    flag_byte[BIT_PER]  = per_hit;
    flag_byte[BIT_ALM]  = alm_hit;
    flag_byte[BIT_UPD]  = upd_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_sec   <= '0;
      last_valid <= 1'b0;
      irq        <= 1'b0;
      flags      <= '0;
    end else begin
      if (!upd_en) begin
        last_valid <= 1'b0;
      end else if (done) begin
        last_sec   <= seconds;
        last_valid <= 1'b1;
      end
      irq   <= any_hit;
      flags <= any_hit ? {8'd1, flag_byte} : 16'd0;
    end
  end

  a_r9_word_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[15:8] == 8'd1 && flags[BIT_PEND] && flags[3:0] == 4'd0));

  a_r9_quiet_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (flags == 16'd0));

  a_r8_alarm_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    flags[BIT_ALM] |-> $past(alm_en));

  a_r7_update_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    flags[BIT_UPD] |-> $past(upd_en));

  a_r6_periodic_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    flags[BIT_PER] |-> $past(per_en));

endmodule

// File: rtl/rtc_tick_emu.sv
module rtc_tick_emu
  import rtc_emu_pkg::*;
#(
  parameter int unsigned BASE_INTERVAL = 2048,
  parameter int unsigned LOST_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       counter_i,
  input  logic [7:0]        hours_i,
  input  logic [7:0]        minutes_i,
  input  logic [7:0]        seconds_i,
  input  logic              upd_en_i,
  input  logic              alm_en_i,
  input  logic              per_en_i,
  input  logic [7:0]        alm_hours_i,
  input  logic [7:0]        alm_minutes_i,
  input  logic [7:0]        alm_seconds_i,
  input  logic [3:0]        rate_code_i,
  output logic [31:0]       cmp_o,
  output logic              catchup_done_o,
  output logic [LOST_W-1:0] lost_ticks_o,
  output logic              irq_o,
  output logic [15:0]       flags_o
);

  localparam logic [31:0] BASE_IV = 32'(BASE_INTERVAL);

  logic        any_en;
  logic [31:0] interval;
  logic        per_hit;

  assign any_en   = upd_en_i || alm_en_i || per_en_i;
  assign interval = tick_interval(rate_code_i, BASE_IV);

  rtc_catchup #(.LOST_W(LOST_W)) u_catchup (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_en   (any_en),
    .counter  (counter_i),
    .interval (interval),
    .cmp      (cmp_o),
    .done     (catchup_done_o),
    .lost     (lost_ticks_o)
  );

  rtc_per_div #(.LOST_W(LOST_W)) u_per_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_en    (per_en_i),
    .done      (catchup_done_o),
    .lost      (lost_ticks_o),
    .rate_code (rate_code_i),
    .per_hit   (per_hit)
  );

  rtc_flag_gen u_flag_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (catchup_done_o),
    .upd_en      (upd_en_i),
    .alm_en      (alm_en_i),
    .per_en      (per_en_i),
    .per_hit     (per_hit),
    .hours       (hours_i),
    .minutes     (minutes_i),
    .seconds     (seconds_i),
    .alm_hours   (alm_hours_i),
    .alm_minutes (alm_minutes_i),
    .alm_seconds (alm_seconds_i),
    .irq         (irq_o),
    .flags       (flags_o)
  );

  a_r4_done_makes_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    catchup_done_o |-> $changed(cmp_o));

endmodule

// File: tb/rtc_tick_emu_bench.sv
module rtc_tick_emu_bench;

  localparam int unsigned BASE = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] counter_i = '0;
  logic [7:0]  hours_i = '0, minutes_i = '0, seconds_i = '0;
  logic        upd_en_i = 1'b0, alm_en_i = 1'b0, per_en_i = 1'b0;
  logic [7:0]  alm_hours_i = '0, alm_minutes_i = '0, alm_seconds_i = '0;
  logic [3:0]  rate_code_i = 4'd6;
  logic [31:0] cmp_o;
  logic        catchup_done_o;
  logic [15:0] lost_ticks_o;
  logic        irq_o;
  logic [15:0] flags_o;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] m_cmp = '0;
  int          m_div = 0;
  logic [7:0]  m_last = '0;
  logic        m_valid = 1'b0;

  always #4 clk = ~clk;

  rtc_tick_emu u_rtc_tick_emu (
    .clk(clk), .rst_n(rst_n), .counter_i(counter_i),
    .hours_i(hours_i), .minutes_i(minutes_i), .seconds_i(seconds_i),
    .upd_en_i(upd_en_i), .alm_en_i(alm_en_i), .per_en_i(per_en_i),
    .alm_hours_i(alm_hours_i), .alm_minutes_i(alm_minutes_i),
    .alm_seconds_i(alm_seconds_i), .rate_code_i(rate_code_i),
    .cmp_o(cmp_o), .catchup_done_o(catchup_done_o),
    .lost_ticks_o(lost_ticks_o), .irq_o(irq_o), .flags_o(flags_o)
  );

  function automatic int eff_code(input int code);
    if (code < 1) return 1;
    if (code > 13) return 13;
    return code;
  endfunction

  function automatic int exp_interval(input int code);
    int c;
    int v;
    c = eff_code(code);
    v = BASE;
    for (int k = 6; k < c; k++) v = v / 2;
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int exp_limit(input int code);
    int c;
    c = eff_code(code);
    return (c >= 6) ? 1 : (64 >> c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_upd(input logic v);
    upd_en_i = v;
    if (!v) m_valid = 1'b0;
  endtask

  task automatic do_tick(input int skip, input int code);
    int iv;
    int waited;
    logic p, a, u, any;
    rate_code_i = 4'(code);
    iv = exp_interval(code);
    counter_i = m_cmp + 32'(skip * iv) + 32'($urandom_range(iv - 1, 0));
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!catchup_done_o && waited < 200);
    check("R3 R4 done seen", 32'(catchup_done_o), 32'd1);
    check("R3 R5 comparator", cmp_o, m_cmp + 32'((skip + 1) * iv));
    check("R4 lost ticks", 32'(lost_ticks_o), 32'(skip));
    m_cmp = m_cmp + 32'((skip + 1) * iv);
    p = 1'b0;
    if (per_en_i) begin
      m_div = m_div + 1 + skip;
      if (m_div >= exp_limit(code)) begin
        p = 1'b1;
        m_div = 0;
      end
    end else begin
      m_div = 0;
    end
    a = alm_en_i && hours_i == alm_hours_i && minutes_i == alm_minutes_i &&
        seconds_i == alm_seconds_i;
    u = 1'b0;
    if (upd_en_i) begin
      u = m_valid && (seconds_i != m_last);
      m_last = seconds_i;
      m_valid = 1'b1;
    end
    any = p | a | u;
    @(negedge clk);
    check("R9 irq pulse", 32'(irq_o), 32'(any));
    check("R6 R7 R8 R9 flag word", 32'(flags_o),
          any ? {16'd0, 8'd1, 1'b1, p, a, u, 4'd0} : 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cmp", cmp_o, 32'd0);
    check("R1 done", 32'(catchup_done_o), 32'd0);
    check("R1 irq", 32'(irq_o), 32'd0);
    check("R1 flags", 32'(flags_o), 32'd0);
    check("R1 lost", 32'(lost_ticks_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: no enable, counter far ahead, comparator frozen
    counter_i = 32'd50000;
    repeat (10) begin
      @(negedge clk);
      check("R10 no done", 32'(catchup_done_o), 32'd0);
    end
    check("R10 cmp frozen", cmp_o, 32'd0);

    // R2 R3: enable periodic at 64 Hz, catch-up over many lost steps
    per_en_i = 1'b1;
    rate_code_i = 4'd6;
    do_tick((50000 - 0) / BASE, 6);

    // R7: first change after enable not flagged, second is
    set_upd(1'b1);
    seconds_i = 8'd10;
    do_tick(0, 6);
    seconds_i = 8'd11;
    do_tick(0, 6);
    seconds_i = 8'd12;
    do_tick(1, 6);
    do_tick(0, 6);

    // R6: slow rate 2 Hz, limit 32, lost credit
    do_tick(30, 1);
    do_tick(0, 1);
    do_tick(2, 1);

    // R5: fast rates and clamping
    do_tick(0, 13);
    do_tick(3, 15);
    do_tick(0, 0);
    do_tick(1, 9);

    // R8: alarm match
    alm_en_i = 1'b1;
    hours_i = 8'd7; minutes_i = 8'd30; seconds_i = 8'd45;
    alm_hours_i = 8'd7; alm_minutes_i = 8'd30; alm_seconds_i = 8'd45;
    do_tick(0, 4);
    minutes_i = 8'd31;
    do_tick(0, 4);

    // R7 re-enable clears history
    set_upd(1'b0);
    @(negedge clk);
    set_upd(1'b1);
    seconds_i = 8'd50;
    do_tick(0, 3);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      set_upd(1'($urandom_range(1, 0)));
      alm_en_i = 1'($urandom_range(1, 0));
      per_en_i = 1'($urandom_range(1, 0));
      if (!upd_en_i && !alm_en_i && !per_en_i) per_en_i = 1'b1;
      if ($urandom_range(1, 0) == 1) seconds_i = 8'($urandom_range(59, 0));
      if ($urandom_range(3, 0) == 0) begin
        alm_hours_i = hours_i; alm_minutes_i = minutes_i; alm_seconds_i = seconds_i;
      end
      do_tick(int'($urandom_range(4, 0)), int'($urandom_range(14, 0)));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule